// File: doc/BRIEF.md
# Upset-Counting Shift Chain Tester

This block measures single-event upset rates in a long chain of flip-flops exposed to radiation. The chain sits outside the tester and is reached through three pins: a shift enable, a serial input and a serial output. While `run_i` is held high, the tester loads the chain with a repeating 0,0,1,1 bit sequence. It then waits through a programmable exposure interval, which should be about one minute of clock cycles on silicon. After that it shifts the whole chain out and checks every received bit against the sequence it loaded.

Each mismatch is classified by direction. A bit that was loaded as 0 and comes back as 1 increments the rise counter. A bit that was loaded as 1 and comes back as 0 increments the fall counter. During readout the tester shifts the same sequence back in, so the chain is full again when the readout ends and the next exposure starts in the following cycle. A one-cycle done pulse marks the end of each readout, and the counters hold their values until the next readout begins. Both the chain length and the exposure interval are parameters, which lets a simulation use small values.

Top module: `upset_chain_tester`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy_o`, `done_o` and `chain_shift_o` are 0 and both counters are 0.
- R2: When `run_i` is high in the idle state, `busy_o` rises and the tester drives exactly CHAIN_LEN consecutive shift cycles. On the k-th of these cycles (k from 0), `chain_din_o` equals 1 exactly when (k mod 4) is 2 or 3.
- R3: After the fill, `chain_shift_o` stays low for exactly EXPOSE_CYCLES cycles before readout starts.
- R4: Readout is CHAIN_LEN consecutive shift cycles. On readout cycle k, `chain_dout_i` is compared with the bit given by the R2 rule for k, and that same bit is driven on `chain_din_o`, so the chain again holds the fill sequence after readout.
- R5: `cnt_rise_o` counts the readout cycles in which the expected bit is 0 and `chain_dout_i` is 1.
- R6: `cnt_fall_o` counts the readout cycles in which the expected bit is 1 and `chain_dout_i` is 0.
- R7: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R8: Both counters are cleared when a readout starts. Outside readout they hold their values, including through idle, fill and exposure.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last readout shift.
- R10: If `run_i` is high when readout ends, the next exposure begins at once and `busy_o` stays high. If `run_i` is low, the tester goes idle and `busy_o` drops in the cycle after the last readout shift.
- R11: `chain_dout_i` has no effect on the counters outside readout. Old chain contents shifted out during a fill are never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Starts a fill when idle; keeps the measurement looping while high |
| chain_shift_o | output | 1 | Shift enable for the chain under test |
| chain_din_o | output | 1 | Serial bit into the chain |
| chain_dout_i | input | 1 | Serial bit from the last stage of the chain |
| cnt_rise_o | output | CNT_W | Number of 0-to-1 flips found in the last readout |
| cnt_fall_o | output | CNT_W | Number of 1-to-0 flips found in the last readout |
| done_o | output | 1 | One-cycle pulse when a readout completes |
| busy_o | output | 1 | High whenever the tester is not idle |

## Verification
The bench models a 16-stage chain and flips bits in it during exposure. It walks a single flip through every position, so each stage is checked to land in the counter matching its loaded value; this shows that the phase of the sequence and the classification by direction line up along the whole chain. Flipping adjacent pairs covers one bit of each polarity at the pattern's 0/1 boundaries as well as pairs of equal polarity. Flipping the whole chain drives both counters past their maximum, and a pass with no flips afterwards shows that the counters are cleared. A chain loaded with all ones before the first fill shows that contents shifted out during a fill are ignored, and dropping `run_i` shows the return to idle and that the counters keep their values until the next readout.

// File: rtl/upt_pkg.sv
package upt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_EXPOSE = 2'd2,
        ST_READ   = 2'd3
    } upt_state_e;

endpackage

// File: rtl/upt_ctrl.sv
module upt_ctrl
    import upt_pkg::*;
#(
    parameter int              CHAIN_LEN     = 1500,
    parameter longint unsigned EXPOSE_CYCLES = 64'd2400000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic shift_o,
    output logic reading_o,
    output logic restart_o,
    output logic read_start_o,
    output logic done_o,
    output logic busy_o
);

    localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int TMR_W = (EXPOSE_CYCLES > 1) ? $clog2(EXPOSE_CYCLES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAIN_LEN - 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(EXPOSE_CYCLES - 64'd1);

    typedef struct packed {
        upt_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [TMR_W-1:0] timer;
        logic             done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (run_i) begin
                    ctrl_d.state = ST_FILL;
                    ctrl_d.idx   = '0;
                end
            end
            ST_FILL: begin
                if (ctrl_q.idx == IDX_LAST) begin
                    ctrl_d.state = ST_EXPOSE;
                    ctrl_d.timer = '0;
                end else begin
                    ctrl_d.idx = ctrl_q.idx + IDX_W'(1);
                end
            end
            ST_EXPOSE: begin
                if (ctrl_q.timer == TMR_LAST) begin
                    ctrl_d.state = ST_READ;
                    ctrl_d.idx   = '0;
                end else begin
                    ctrl_d.timer = ctrl_q.timer + TMR_W'(1);
                end
            end
            ST_READ: begin
                if (ctrl_q.idx == IDX_LAST) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.timer = '0;
                    ctrl_d.state = run_i ? ST_EXPOSE : ST_IDLE;
                end else begin
                    ctrl_d.idx = ctrl_q.idx + IDX_W'(1);
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: ST_IDLE, idx: '0, timer: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign shift_o      = (ctrl_q.state == ST_FILL) || (ctrl_q.state == ST_READ);
    assign reading_o    = (ctrl_q.state == ST_READ);
    assign busy_o       = (ctrl_q.state != ST_IDLE);
    assign done_o       = ctrl_q.done;
    assign read_start_o = (ctrl_d.state == ST_READ) && (ctrl_q.state != ST_READ);
    assign restart_o    = read_start_o ||
                          ((ctrl_d.state == ST_FILL) && (ctrl_q.state != ST_FILL));

    // R9: the done pulse never lasts two cycles
    a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2: a run request in idle starts shifting in the next cycle, as a fill
    a_r2_fill_follows_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.state == ST_IDLE && run_i) |=> (shift_o && !reading_o && busy_o));

    // R3: readout is only ever entered from the exposure wait
    a_r3_read_after_expose: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reading_o ##1 reading_o) |-> ($past(ctrl_q.state) == ST_EXPOSE));

    // R10: the last readout shift with run low returns to idle with done
    a_r10_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reading_o && ctrl_q.idx == IDX_LAST && !run_i) |=> (!busy_o && done_o));

endmodule

// File: rtl/upt_phase.sv
module upt_phase (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic step_i,
    output logic bit_o
);

    typedef struct packed {
        logic [1:0] phase;
    } phase_s;

    phase_s phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (restart_i) begin
            phase_d.phase = 2'd0;
        end else if (step_i) begin
            phase_d.phase = phase_q.phase + 2'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '{phase: 2'd0};
        end else begin
            phase_q <= phase_d;
        end
    end

    // 0,0,1,1 repeating: the upper phase bit
    assign bit_o = phase_q.phase[1];

    // R4: every pass starts at the first position of the sequence
    a_r4_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (phase_q.phase == 2'd0 && !bit_o));

    // R2: each shift moves one position along the sequence
    a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !restart_i) |=> (phase_q.phase == $past(phase_q.phase) + 2'd1));

endmodule

// File: rtl/upt_sat_counter.sv
module upt_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.count = '0;
        end else if (hit_i && cnt_q.count != CNT_MAX) begin
            cnt_d.count = cnt_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '{count: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;

    // R7: a full counter stays full until cleared
    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == CNT_MAX && !clear_i) |=> (count_o == CNT_MAX));

    // R8: clearing always lands on zero
    a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (count_o == '0));

    // R8: without a hit or clear the count is frozen
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !hit_i) |=> $stable(count_o));

    // R5, R6: a hit below the limit adds exactly one
    a_r5_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && hit_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: rtl/upset_chain_tester.sv
module upset_chain_tester #(
    parameter int              CHAIN_LEN     = 1500,
    parameter longint unsigned EXPOSE_CYCLES = 64'd2400000000,
    parameter int              CNT_W         = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    output logic             chain_shift_o,
    output logic             chain_din_o,
    input  logic             chain_dout_i,
    output logic [CNT_W-1:0] cnt_rise_o,
    output logic [CNT_W-1:0] cnt_fall_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int N_DIR = 2;

    logic             reading;
    logic             restart;
    logic             read_start;
    logic             exp_bit;
    logic [N_DIR-1:0] hit;
    logic [CNT_W-1:0] counts [N_DIR];

    upt_ctrl #(
        .CHAIN_LEN     (CHAIN_LEN),
        .EXPOSE_CYCLES (EXPOSE_CYCLES)
    ) ctrl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run_i),
        .shift_o      (chain_shift_o),
        .reading_o    (reading),
        .restart_o    (restart),
        .read_start_o (read_start),
        .done_o       (done_o),
        .busy_o       (busy_o)
    );

    upt_phase phase_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .step_i    (chain_shift_o),
        .bit_o     (exp_bit)
    );

    assign chain_din_o = exp_bit;

    // Index 0 counts received zeros (fall), index 1 received ones (rise)
    for (genvar gd = 0; gd < N_DIR; gd++) begin : g_dir
        localparam logic DIR_BIT = (gd == 1);
        assign hit[gd] = reading && (chain_dout_i == DIR_BIT) && (exp_bit != DIR_BIT);
        upt_sat_counter #(
            .CNT_W (CNT_W)
        ) cnt_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (read_start),
            .hit_i   (hit[gd]),
            .count_o (counts[gd])
        );
    end

    assign cnt_rise_o = counts[1];
    assign cnt_fall_o = counts[0];

    // R11: outside readout nothing on the chain output moves the counters
    a_r11_idle_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reading && !read_start) |=> ($stable(cnt_rise_o) && $stable(cnt_fall_o)));

    // R5: a received zero never raises the rise count
    a_r5_rise_needs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reading && !chain_dout_i) |=> $stable(cnt_rise_o));

    // R6: a received one never raises the fall count
    a_r6_fall_needs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reading && chain_dout_i) |=> $stable(cnt_fall_o));

endmodule

// File: tb/upset_chain_tester_tb.sv
`timescale 1ns/1ps
module upset_chain_tester_tb_top;

    localparam int              L   = 16;
    localparam longint unsigned EXP = 64'd20;
    localparam int              CW  = 3;
    localparam int              CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          shift, din, done, busy;
    logic [CW-1:0] rise, fall;

    logic [L-1:0]  chain = '1;
    logic [L-1:0]  inj_mask = '0;
    logic          inj_req = 1'b0;
    logic          inj_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    upset_chain_tester #(
        .CHAIN_LEN     (L),
        .EXPOSE_CYCLES (EXP),
        .CNT_W         (CW)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .run_i         (run),
        .chain_shift_o (shift),
        .chain_din_o   (din),
        .chain_dout_i  (chain[L-1]),
        .cnt_rise_o    (rise),
        .cnt_fall_o    (fall),
        .done_o        (done),
        .busy_o        (busy)
    );

    // Chain model: shifts toward the top index, flips applied while idle
    always @(posedge clk) begin
        if (shift) chain <= {chain[L-2:0], din};
        else if (inj_req != inj_ack) chain <= chain ^ inj_mask;
        inj_ack <= inj_req;
    end

    function automatic logic [L-1:0] fill_vec();
        logic [L-1:0] v;
        for (int j = 0; j < L; j++) v[j] = (((L - 1 - j) % 4) >= 2);
        return v;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done_count(output int nread);
        nread = 0;
        while (!done) begin
            if (shift) nread++;
            @(negedge clk);
        end
    endtask

    task automatic do_pass(input logic [L-1:0] mask, input logic keep_run);
        logic [L-1:0] fv;
        int er, ef, nr;
        fv = fill_vec();
        er = 0; ef = 0;
        for (int j = 0; j < L; j++) begin
            if (mask[j]) begin
                if (fv[j]) ef++;
                else er++;
            end
        end
        if (er > CMAX) er = CMAX;
        if (ef > CMAX) ef = CMAX;
        inj_mask = mask;
        inj_req  = ~inj_req;
        if (!keep_run) run = 1'b0;
        @(negedge clk);
        wait_done_count(nr);
        chk("R4 readout length", nr, L);
        chk("R5 rise count", rise, er);
        chk("R6 fall count", fall, ef);
        chk("R4 chain refilled", chain, fv);
        chk("R10 busy after readout", busy, keep_run);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
    endtask

    initial begin
        int n;
        logic [L-1:0] m;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 shift in reset", shift, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 counts after reset", {rise, fall}, 0);
        run = 1'b1;
        @(negedge clk);
        chk("R2 busy on run", busy, 1);
        n = 0;
        while (shift) begin n++; @(negedge clk); end
        chk("R2 fill length", n, L);
        chk("R2 fill pattern", chain, fill_vec());
        n = 0;
        while (!shift) begin n++; @(negedge clk); end
        chk("R3 exposure length", n, EXP);
        wait_done_count(n);
        chk("R9 done after last shift", n, L);
        chk("R11 old contents ignored rise", rise, 0);
        chk("R11 old contents ignored fall", fall, 0);
        chk("R4 chain refilled first pass", chain, fill_vec());
        chk("R10 continues exposure", busy, 1);
        chk("R10 no shift right after", shift, 0);
        // single flip at every stage
        for (int j = 0; j < L; j++) begin
            m = '0; m[j] = 1'b1;
            do_pass(m, 1'b1);
        end
        // adjacent pairs
        for (int j = 0; j < L - 1; j++) begin
            m = '0; m[j] = 1'b1; m[j+1] = 1'b1;
            do_pass(m, 1'b1);
        end
        // R7 saturation: every bit flipped
        do_pass('1, 1'b1);
        // R8 clear: clean pass after saturation
        do_pass('0, 1'b1);
        // R10 stop: saturate again with run dropped
        do_pass('1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R10 idle busy", busy, 0);
        chk("R10 idle shift", shift, 0);
        chk("R8 held in idle rise", rise, CMAX);
        chk("R8 held in idle fall", fall, CMAX);
        run = 1'b1;
        @(negedge clk);
        while (shift) @(negedge clk);
        chk("R8 held through fill", rise, CMAX);
        wait_done_count(n);
        chk("R8 cleared on new readout", {rise, fall}, 0);
        chk("R2 restart refill", chain, fill_vec());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule